// File: doc/BRIEF.md
# PLL divider search engine

This block picks the integer settings of a clock-multiplying PLL that serves a high-speed serial link. A controller gives it the per-lane data rate in Mbps and the reference clock in kHz, then pulses `start`. The engine works out a target output frequency, chooses a VCO post-divider, and then steps through every allowed input divider N. For each N it derives a rounded feedback multiplier M and the output frequency that this M really gives. It keeps the candidate that lands closest to the target.

One restoring divider does all the division work. Each N needs two divisions, one for M and one for the achieved frequency. A search therefore takes a few thousand cycles at most. During that time `busy` is high and the previous result stays on the outputs. When the search ends, `done` pulses for one cycle. At that point either `ok` is high with the encoded M, N, output frequency and post-divider, or `err` is high with every result field at zero.

Top module: `pll_div_search`

## Requirements
- R1: A `start` with `rate_mbps` below 80 or above 2500 runs no search: `done` and `err` are high in the cycle after `start` is sampled.
- R2: A `start` with `fin_khz` below 2000 or above 64000 is rejected in the same way as R1.
- R3: The target frequency is `rate_mbps`×500 kHz. The post-divider is 8 when the target is at most 80000 kHz, 4 when at most 160000, 2 when at most 320000, and 1 otherwise. `postdiv` carries the value 1, 2, 4 or 8 directly.
- R4: Candidate dividers are N = 1..16 taken in ascending order. Only those with 2000·N ≤ Fin ≤ 8000·N are tried.
- R5: For each candidate, M = floor((2·Ftarget·N·postdiv + Fin) / (2·Fin)), which is the quotient rounded to nearest with halves going up. A candidate with M outside 64..625 is dropped.
- R6: The achieved frequency is floor(M·Fin / (N·postdiv)) kHz. A candidate whose achieved frequency is below 40000 kHz or above 1250000 kHz is dropped.
- R7: A surviving candidate replaces the best one only if its absolute error is strictly smaller. On equal errors the smallest N is kept.
- R8: If no candidate survives, the search ends with `err` high and `ok` low.
- R9: On success `m_code` = M−2 (10 bits), `n_code` = N−1 (4 bits), `fout_khz` = achieved frequency. On any error `m_code`, `n_code`, `fout_khz` and `postdiv` are all zero.
- R10: From an accepted `start` until `done`, `busy` stays high, a further `start` is ignored, and every result output holds its previous value.
- R11: `done` is a single-cycle pulse with exactly one of `ok`/`err` high. After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search (sampled when idle) |
| rate_mbps | input | 12 | Per-lane data rate in Mbps |
| fin_khz | input | 17 | Reference frequency in kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Last request produced a setting |
| err | output | 1 | Last request was rejected or had no solution |
| m_code | output | 10 | Multiplier field, M−2 |
| n_code | output | 4 | Divider field, N−1 |
| fout_khz | output | 21 | Achieved output frequency in kHz |
| postdiv | output | 4 | Post-divider value 1, 2, 4 or 8 |

## Verification
Some properties can be checked on every cycle, and the assertions cover those. They check that an out-of-range rate or reference is rejected one cycle after start. They check that results hold still while busy, that done is a lone pulse with exactly one flag, and that successful fields stay inside the M and frequency limits with a power-of-two post-divider. Other behaviour only the bench's scenarios can show. These are which N wins, including ties, the rounding of M, the post-divider thresholds, the no-solution case, and a start that arrives in mid-search being ignored. The bench checks them by computing each expected result from the arithmetic rules and comparing outputs on every clock.

// File: rtl/pll_div_search.sv
module pll_div_search #(
  parameter int RATE_W   = 12,
  parameter int FIN_W    = 17,
  parameter int DW       = 48,
  parameter int M_W      = 10,
  parameter int N_W      = 4,
  parameter int F_W      = 21,
  parameter int NCAND    = 16,
  parameter int RATE_MIN = 80,
  parameter int RATE_MAX = 2500,
  parameter int FIN_MIN  = 2000,
  parameter int FIN_MAX  = 64000,
  parameter int M_MIN    = 64,
  parameter int M_MAX    = 625,
  parameter int F_MIN    = 40000,
  parameter int F_MAX    = 1250000,
  parameter int PD_STEP  = 80000,
  parameter int PFD_LO   = 2000,
  parameter int PFD_HI   = 8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RATE_W-1:0] rate_mbps,
  input  logic [FIN_W-1:0]  fin_khz,
  output logic              busy,
  output logic              done,
  output logic              ok,
  output logic              err,
  output logic [M_W-1:0]    m_code,
  output logic [N_W-1:0]    n_code,
  output logic [F_W-1:0]    fout_khz,
  output logic [3:0]        postdiv
);
  localparam int CW   = $clog2(DW + 1);
  localparam int NQW  = $clog2(NCAND + 1);
  localparam int HALF = 500;

  typedef enum logic [2:0] {S_IDLE, S_NEXT, S_MDIV, S_MCHK, S_FDIV, S_FCHK, S_END} st_t;
  st_t st;

  logic [RATE_W-1:0] rate_q;
  logic [FIN_W-1:0]  fin_q;
  logic [3:0]        pd_q;
  logic [NQW-1:0]    n_q, best_n;
  logic [DW:0]       rem;
  logic [DW-1:0]     quo, den, cur_m, best_d, best_f;
  logic [M_W-1:0]    best_m;
  logic [CW-1:0]     cnt;
  logic              found;

  logic [DW-1:0] tgt_in, tgt, n_x, pd_x, fin_x, delta;
  logic [DW:0]   trial;
  logic          fits, in_rng, m_ok, f_ok, valid_in, last_n;
  logic [3:0]    pd_in;

  assign tgt_in = DW'(rate_mbps) * DW'(HALF);
  assign pd_in  = tgt_in <= DW'(PD_STEP)     ? 4'd8 :
                  tgt_in <= DW'(2 * PD_STEP) ? 4'd4 :
                  tgt_in <= DW'(4 * PD_STEP) ? 4'd2 : 4'd1;
  assign valid_in = DW'(rate_mbps) >= DW'(RATE_MIN) && DW'(rate_mbps) <= DW'(RATE_MAX) &&
                    DW'(fin_khz) >= DW'(FIN_MIN) && DW'(fin_khz) <= DW'(FIN_MAX);

  assign tgt    = DW'(rate_q) * DW'(HALF);
  assign n_x    = DW'(n_q);
  assign pd_x   = DW'(pd_q);
  assign fin_x  = DW'(fin_q);
  assign in_rng = DW'(PFD_HI) * n_x >= fin_x && DW'(PFD_LO) * n_x <= fin_x;
  assign m_ok   = quo >= DW'(M_MIN) && quo <= DW'(M_MAX);
  assign f_ok   = quo >= DW'(F_MIN) && quo <= DW'(F_MAX);
  assign delta  = quo > tgt ? quo - tgt : tgt - quo;
  assign last_n = n_q == NQW'(NCAND);

  assign trial = {rem[DW-1:0], quo[DW-1]};
  assign fits  = trial >= {1'b0, den};
  assign busy  = st != S_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; done <= 1'b0; ok <= 1'b0; err <= 1'b0;
      m_code <= '0; n_code <= '0; fout_khz <= '0; postdiv <= '0;
      rate_q <= '0; fin_q <= '0; pd_q <= '0; n_q <= '0;
      rem <= '0; quo <= '0; den <= '0; cnt <= '0; cur_m <= '0;
      best_d <= '1; best_f <= '0; best_m <= '0; best_n <= '0; found <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          rate_q <= rate_mbps; fin_q <= fin_khz; pd_q <= pd_in;
          n_q <= NQW'(1); found <= 1'b0; best_d <= '1;
          if (valid_in) st <= S_NEXT;
          else begin
            done <= 1'b1; ok <= 1'b0; err <= 1'b1;
            m_code <= '0; n_code <= '0; fout_khz <= '0; postdiv <= '0;
          end
        end
        S_NEXT: if (in_rng) begin
          rem <= '0; cnt <= CW'(DW);
          quo <= DW'(2) * tgt * n_x * pd_x + fin_x;
          den <= DW'(2) * fin_x;
          st  <= S_MDIV;
        end else if (last_n) st <= S_END;
        else n_q <= n_q + NQW'(1);
        S_MDIV, S_FDIV: begin
          rem <= fits ? trial - {1'b0, den} : trial;
          quo <= {quo[DW-2:0], fits};
          cnt <= cnt - CW'(1);
          if (cnt == CW'(1)) st <= (st == S_MDIV) ? S_MCHK : S_FCHK;
        end
        S_MCHK: if (m_ok) begin
          cur_m <= quo; rem <= '0; cnt <= CW'(DW);
          quo <= quo * fin_x;
          den <= n_x * pd_x;
          st  <= S_FDIV;
        end else if (last_n) st <= S_END;
        else begin n_q <= n_q + NQW'(1); st <= S_NEXT; end
        S_FCHK: begin
          if (f_ok && delta < best_d) begin
            best_d <= delta; best_f <= quo; best_m <= cur_m[M_W-1:0];
            best_n <= n_q; found <= 1'b1;
          end
          if (last_n) st <= S_END;
          else begin n_q <= n_q + NQW'(1); st <= S_NEXT; end
        end
        S_END: begin
          done <= 1'b1; ok <= found; err <= !found;
          m_code   <= found ? best_m - M_W'(2) : '0;
          n_code   <= found ? N_W'(best_n - NQW'(1)) : '0;
          fout_khz <= found ? best_f[F_W-1:0] : '0;
          postdiv  <= found ? pd_q : '0;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_div_search_chk.sv
module pll_div_search_chk #(
  parameter int RATE_W = 12, parameter int FIN_W = 17, parameter int M_W = 10,
  parameter int F_W = 21, parameter int RATE_MIN = 80, parameter int RATE_MAX = 2500,
  parameter int FIN_MIN = 2000, parameter int FIN_MAX = 64000,
  parameter int M_MIN = 64, parameter int M_MAX = 625,
  parameter int F_MIN = 40000, parameter int F_MAX = 1250000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [RATE_W-1:0] rate_mbps,
  input logic [FIN_W-1:0]  fin_khz,
  input logic              busy,
  input logic              done,
  input logic              ok,
  input logic              err,
  input logic [M_W-1:0]    m_code,
  input logic [F_W-1:0]    fout_khz,
  input logic [3:0]        postdiv
);
  assert_reject_rate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (int'(rate_mbps) < RATE_MIN || int'(rate_mbps) > RATE_MAX)) |=> (done && err));
  assert_reject_fin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (int'(fin_khz) < FIN_MIN || int'(fin_khz) > FIN_MAX)) |=> (done && err));
  assert_postdiv_pow2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> $countones(postdiv) == 1);
  assert_m_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> (int'(m_code) >= M_MIN - 2 && int'(m_code) <= M_MAX - 2));
  assert_fout_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> (int'(fout_khz) >= F_MIN && int'(fout_khz) <= F_MAX));
  assert_err_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (m_code == '0 && fout_khz == '0 && postdiv == '0));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (done || ($stable(m_code) && $stable(fout_khz) && $stable(ok) && $stable(err))));
  assert_busy_until_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));
  assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);
  assert_one_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ok != err));
endmodule

bind pll_div_search pll_div_search_chk #(
  .RATE_W(RATE_W), .FIN_W(FIN_W), .M_W(M_W), .F_W(F_W),
  .RATE_MIN(RATE_MIN), .RATE_MAX(RATE_MAX), .FIN_MIN(FIN_MIN), .FIN_MAX(FIN_MAX),
  .M_MIN(M_MIN), .M_MAX(M_MAX), .F_MIN(F_MIN), .F_MAX(F_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rate_mbps(rate_mbps), .fin_khz(fin_khz),
  .busy(busy), .done(done), .ok(ok), .err(err), .m_code(m_code),
  .fout_khz(fout_khz), .postdiv(postdiv)
);

// File: tb/test_pll_div_search.sv
module test_pll_div_search;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] rate_mbps = '0;
  logic [16:0] fin_khz = '0;
  logic        busy, done, ok, err;
  logic [9:0]  m_code;
  logic [3:0]  n_code;
  logic [20:0] fout_khz;
  logic [3:0]  postdiv;

  int n_chk = 0;
  int n_err = 0;
  longint h_ok = 0, h_err = 0, h_m = 0, h_n = 0, h_f = 0, h_pd = 0;

  always #5 clk = ~clk;

  pll_div_search i_pll_div_search (
    .clk(clk), .rst_n(rst_n), .start(start), .rate_mbps(rate_mbps), .fin_khz(fin_khz),
    .busy(busy), .done(done), .ok(ok), .err(err), .m_code(m_code), .n_code(n_code),
    .fout_khz(fout_khz), .postdiv(postdiv)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ref_search(input longint rate, input longint fin, output longint e_ok,
                            output longint e_m, output longint e_n, output longint e_f,
                            output longint e_pd);
    longint tgt, pd, m, f, d, best;
    e_ok = 0; e_m = 0; e_n = 0; e_f = 0; e_pd = 0;
    if (rate < 80 || rate > 2500 || fin < 2000 || fin > 64000) return;
    tgt = rate * 500;
    if (tgt <= 80000) pd = 8;
    else if (tgt <= 160000) pd = 4;
    else if (tgt <= 320000) pd = 2;
    else pd = 1;
    best = 64'h7fffffffffffffff;
    for (longint n = 1; n <= 16; n++) begin
      if (8000 * n < fin || 2000 * n > fin) continue;
      m = (2 * tgt * n * pd + fin) / (2 * fin);
      if (m < 64 || m > 625) continue;
      f = (m * fin) / (n * pd);
      if (f < 40000 || f > 1250000) continue;
      d = (f > tgt) ? f - tgt : tgt - f;
      if (d < best) begin
        best = d; e_ok = 1; e_m = m - 2; e_n = n - 1; e_f = f; e_pd = pd;
      end
    end
  endtask

  task automatic check_held(input string req);
    chk({req, " ok held"}, longint'(ok), h_ok);
    chk({req, " err held"}, longint'(err), h_err);
    chk({req, " m held"}, longint'(m_code), h_m);
    chk({req, " n held"}, longint'(n_code), h_n);
    chk({req, " fout held"}, longint'(fout_khz), h_f);
    chk({req, " postdiv held"}, longint'(postdiv), h_pd);
  endtask

  task automatic run(input string req, input int rate, input int fin, input bit glitch);
    longint e_ok, e_m, e_n, e_f, e_pd;
    int got;
    ref_search(rate, fin, e_ok, e_m, e_n, e_f, e_pd);
    @(negedge clk);
    start = 1'b1; rate_mbps = 12'(rate); fin_khz = 17'(fin);
    @(negedge clk);
    start = 1'b0;
    got = -1;
    for (int c = 0; c < 4000; c++) begin
      if (done) begin got = c; break; end
      chk({req, " R10 busy during search"}, longint'(busy), 1);
      check_held({req, " R10"});
      if (glitch && c == 5) begin start = 1'b1; rate_mbps = 12'd700; fin_khz = 17'd12000; end
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    if (got < 0) chk({req, " done seen"}, 0, 1);
    chk({req, " R11 busy low at done"}, longint'(busy), 0);
    chk({req, " R11 ok"}, longint'(ok), e_ok);
    chk({req, " R8 err"}, longint'(err), 1 - e_ok);
    chk({req, " R9 m_code"}, longint'(m_code), e_m);
    chk({req, " R9 n_code"}, longint'(n_code), e_n);
    chk({req, " R6 fout"}, longint'(fout_khz), e_f);
    chk({req, " R3 postdiv"}, longint'(postdiv), e_pd);
    if (rate < 80 || rate > 2500 || fin < 2000 || fin > 64000)
      chk({req, " R1/R2 reject latency"}, got, 0);
    h_ok = e_ok; h_err = 1 - e_ok; h_m = e_m; h_n = e_n; h_f = e_f; h_pd = e_pd;
    @(negedge clk);
    chk({req, " R11 done pulse"}, longint'(done), 0);
    check_held({req, " R11 after done"});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset busy", longint'(busy), 0);
    chk("R11 reset done", longint'(done), 0);
    check_held("R11 reset");
    rst_n = 1'b1;
    @(negedge clk);
    // R1 rate limits
    run("R1 rate 79", 79, 24000, 0);
    run("R1 rate 2501", 2501, 24000, 0);
    run("R1 rate 80", 80, 24000, 0);
    run("R1 rate 2500", 2500, 24000, 0);
    // R2 reference limits
    run("R2 fin 1999", 1000, 1999, 0);
    run("R2 fin 64001", 1000, 64001, 0);
    run("R2 fin 2000", 1000, 2000, 0);
    run("R2 fin 64000", 1000, 64000, 0);
    // R3 post-divider thresholds
    run("R3 rate 160", 160, 24000, 0);
    run("R3 rate 161", 161, 24000, 0);
    run("R3 rate 320", 320, 24000, 0);
    run("R3 rate 321", 321, 24000, 0);
    run("R3 rate 640", 640, 24000, 0);
    run("R3 rate 641", 641, 24000, 0);
    // R4 R5 R6 general patterns
    run("R4 R5 rate 891 fin 24000", 891, 24000, 0);
    run("R5 R6 rate 1188 fin 19200", 1188, 19200, 0);
    run("R4 rate 445 fin 12000", 445, 12000, 0);
    run("R5 rate 1777 fin 27001", 1777, 27001, 0);
    // R7 tie: every N in 2..8 is exact, so N=2 (n_code 1, m_code 78) must win
    run("R7 tie", 160, 16000, 0);
    chk("R7 tie smallest N", longint'(n_code), 1);
    chk("R7 tie m_code", longint'(m_code), 78);
    // R8 only N=1 allowed and it overshoots the frequency ceiling
    run("R8 no survivor", 2500, 2001, 0);
    // R10 start in mid-search is ignored
    run("R10 glitch start", 1500, 27000, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule